// File: doc/BRIEF.md
# PCI Type-0 Configuration Register File

This block is the configuration register file of a type-0 PCI function. It decodes a dword-indexed space of 1024 registers. Each register holds 32 bits and carries its own per-bit writable mask. Reads are combinational and return a whole dword. A write names a dword index, a byte offset inside that dword, and an access length of 1, 2 or 4 bytes. The new data is merged under the writable mask, so read-only bits keep their value.

Only a few registers hold writable state:
- the command word;
- the cache-line byte;
- one 64-bit memory BAR pair;
- the expansion-ROM BAR;
- the interrupt-line byte;
- the MSI and MSI-X capability header dwords.

Everything else is either a constant fixed by parameters (identity, class, subsystem, capability pointer) or reads as zero. The BAR answers an all-ones dword write with its size encoding. The ROM BAR ignores sizing writes.

A write that touches the MSI-X header's message-control half raises a one-cycle strobe with the new control value. A surrounding interrupt unit uses it to track enable and function-mask changes.

Top module: `cfgsp_top`

## Requirements
- R1: A read of any index at or beyond NUM_REGS (1024) returns 0xFFFF_FFFF. A write to such an index changes no register.
- R2: A write stores (old & ~W) | (new & E). W is the register's writable mask, and E is W unless R7 narrows it. At reset W is 0x0000_FFFF for index 1, 0x0000_00FF for index 3 and 0x0000_00FF for index 15. Every register without writable state reads its reset value forever.
- R3: After reset, index 0 reads {DEVICE_ID, VENDOR_ID}, index 2 reads {CLASS_CODE (class, subclass, prog-IF), REVISION} and index 11 reads SUBSYS_ID. Writes never alter them.
- R4: Write data is right-aligned in wr_data and moved up by 8×wr_off bits. A 1-byte write may use any of the four lanes. A 2-byte write is accepted only at offset 0 or 2.
- R5: An access with wr_off + wr_len greater than 4, or a wr_len other than 1, 2 or 4, is dropped with no effect.
- R6: The BAR pair is the low dword at index 4 and the high dword at index 5. Index 4 has writable mask 0xFFFF_FFF0, and its low nibble always reads 0b0100 (64-bit memory type). Index 5 is fully writable. Both reset to BAR_BASE.
- R7: A 4-byte write of 0xFFFF_FFFF to a BAR index (4 to 9) has its stored bits further ANDed with the matching half of ~(2^BAR_SIZE_LOG2 − 1). The BAR then reads back its size encoding.
- R8: The ROM BAR at index 12 resets to 0 and has writable mask ROM_WMASK (default 0xFFFF_F801). A 4-byte write whose bits 31:11 are all ones is ignored entirely.
- R9: Status bit 20 of index 1 reads 1 whenever a capability is enabled. Byte 0x34 (index 13, bits 7:0) holds the first capability offset, which is 0x40 by default. The MSI header's next pointer is the MSI-X header offset.
- R10: The MSI header dword (index MSI_DW, capability ID 0x05 in bits 7:0) has writable mask 0x0071_0000.
- R11: The MSI-X header dword (index MSIX_DW, capability ID 0x11) has only bits 31:30 writable.
- R12: A 2-byte write at offset 2, or a 4-byte write at offset 0, to the MSI-X header asserts msix_ctl_stb for exactly the following cycle. During that cycle msix_ctl_val equals bits 31:16 of the header after the write. No other write raises the strobe.
- R13: A write becomes visible on rd_data after the next rising edge. Synchronous active-high reset restores every register to its reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request this cycle |
| wr_idx | input | IDX_W | Dword index of the write |
| wr_off | input | 2 | Byte offset inside the dword |
| wr_len | input | 3 | Access length in bytes |
| wr_data | input | 32 | Write data, right-aligned |
| rd_idx | input | IDX_W | Dword index to read |
| rd_data | output | 32 | Combinational read data |
| msix_ctl_stb | output | 1 | MSI-X message-control write strobe |
| msix_ctl_val | output | 16 | New MSI-X message-control value |

## Verification
The bound checker watches the following on every cycle:
- reads at or past the end of the space return all ones;
- the BAR type nibble and the capability ID bytes stay fixed;
- status bit 20 matches the capability configuration;
- a ROM sizing write leaves the ROM BAR untouched;
- every strobe follows a write to the MSI-X header.

Other behaviour shows up only through the bench's scenarios, which compare each read against a behavioural model:
- lane merging;
- dropping of misaligned and oversized accesses;
- the exact BAR size encoding after an all-ones write;
- the masked update of the MSI control bits;
- restoration after a second reset.

// File: rtl/cfgsp_pkg.sv
package cfgsp_pkg;
   localparam int IDX_ID     = 0;
   localparam int IDX_CMD    = 1;
   localparam int IDX_CLASS  = 2;
   localparam int IDX_CLINE  = 3;
   localparam int IDX_BAR_LO = 4;
   localparam int IDX_BAR_HI = 5;
   localparam int IDX_BAR_END = 9;
   localparam int IDX_SUBSYS = 11;
   localparam int IDX_ROM    = 12;
   localparam int IDX_CAPPTR = 13;
   localparam int IDX_ILINE  = 15;
   localparam int CAP_LO_DW  = 16;   // byte 0x40
   localparam int CAP_HI_DW  = 47;   // byte 0xBC
   localparam logic [7:0] CAPID_MSI  = 8'h05;
   localparam logic [7:0] CAPID_MSIX = 8'h11;
   localparam logic [3:0] BAR_TYPE64 = 4'b0100;
   localparam int STATUS_CAP_BIT = 20;
endpackage

// File: rtl/cfgsp_access_dec.sv
module cfgsp_access_dec #(
   parameter int DW = 32
) (
   input  logic [1:0]    off,
   input  logic [2:0]    len,
   input  logic [DW-1:0] data,
   output logic          ok,
   output logic          full,
   output logic [DW-1:0] lane,
   output logic [DW-1:0] data_sh
);
   localparam int SHW = $clog2(DW);
   logic [SHW-1:0] sh;

   assign sh      = SHW'({off, 3'b000});
   assign data_sh = data << sh;

   always_comb begin
      ok   = 1'b0;
      full = 1'b0;
      lane = '0;
      case (len)
         3'd1: begin
            ok   = 1'b1;
            lane = DW'(8'hFF) << sh;
         end
         3'd2: begin
            ok   = ~off[0];
            lane = DW'(16'hFFFF) << sh;
         end
         3'd4: begin
            ok   = (off == 2'd0);
            full = (off == 2'd0);
            lane = '1;
         end
         default: ok = 1'b0;
      endcase
   end
endmodule

// File: rtl/cfgsp_slot.sv
module cfgsp_slot #(
   parameter int          DW      = 32,
   parameter logic [31:0] RST_VAL = '0,
   parameter logic [31:0] WMASK   = '0
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          we,
   input  logic [DW-1:0] lane,
   input  logic [DW-1:0] narrow,
   input  logic [DW-1:0] data,
   output logic [DW-1:0] q,
   output logic [DW-1:0] d_nxt
);
   localparam logic [DW-1:0] WM = DW'(WMASK);

   assign d_nxt = (q & ~(WM & lane)) | (data & WM & lane & narrow);

   always_ff @(posedge clk) begin
      if (rst)     q <= DW'(RST_VAL);
      else if (we) q <= d_nxt;
   end
endmodule

// File: rtl/cfgsp_top.sv
module cfgsp_top
   import cfgsp_pkg::*;
#(
   parameter int          NUM_REGS      = 1024,
   parameter int          IDX_W         = 12,
   parameter logic [15:0] VENDOR_ID     = 16'hC0DE,
   parameter logic [15:0] DEVICE_ID     = 16'h7A31,
   parameter logic [7:0]  REVISION      = 8'h02,
   parameter logic [23:0] CLASS_CODE    = 24'h04_01_00,
   parameter logic [31:0] SUBSYS_ID     = 32'h2468_ABCD,
   parameter logic [63:0] BAR_BASE      = 64'h0000_0013_1200_0000,
   parameter int          BAR_SIZE_LOG2 = 15,
   parameter logic [31:0] ROM_WMASK     = 32'hFFFF_F801,
   parameter bit          MSI_EN        = 1'b1,
   parameter bit          MSIX_EN       = 1'b1,
   parameter int          MSI_DW        = 16,
   parameter int          MSIX_DW       = 20,
   parameter logic [15:0] MSI_CTL_INIT  = 16'h0080,
   parameter logic [15:0] MSIX_CTL_INIT = 16'h03FF
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [1:0]       wr_off,
   input  logic [2:0]       wr_len,
   input  logic [31:0]      wr_data,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [31:0]      rd_data,
   output logic             msix_ctl_stb,
   output logic [15:0]      msix_ctl_val
);
   localparam int DW    = 32;
   localparam int NSLOT = 8;
   localparam int SL_BLO = 2, SL_BHI = 3, SL_ROM = 4, SL_MSIX = 7;
   localparam bit CAP_ANY = MSI_EN | MSIX_EN;
   localparam logic [63:0] BAR_SZ_MASK = ~((64'd1 << BAR_SIZE_LOG2) - 64'd1);
   localparam logic [7:0] MSI_OFS  = 8'(MSI_DW * 4);
   localparam logic [7:0] MSIX_OFS = 8'(MSIX_DW * 4);
   localparam logic [7:0] FIRST_CAP = MSI_EN ? MSI_OFS : (MSIX_EN ? MSIX_OFS : 8'h00);
   localparam logic [7:0] MSI_NEXT  = MSIX_EN ? MSIX_OFS : 8'h00;

   localparam int SL_IDX [NSLOT] = '{IDX_CMD, IDX_CLINE, IDX_BAR_LO, IDX_BAR_HI,
                                     IDX_ROM, IDX_ILINE, MSI_DW, MSIX_DW};
   localparam logic [31:0] SL_WM [NSLOT] = '{
      32'h0000_FFFF, 32'h0000_00FF, 32'hFFFF_FFF0, 32'hFFFF_FFFF,
      ROM_WMASK, 32'h0000_00FF,
      MSI_EN  ? 32'h0071_0000 : 32'h0,
      MSIX_EN ? 32'hC000_0000 : 32'h0};
   localparam logic [31:0] SL_RST [NSLOT] = '{
      32'(CAP_ANY) << STATUS_CAP_BIT,
      32'h0,
      {BAR_BASE[31:4], BAR_TYPE64},
      BAR_BASE[63:32],
      32'h0,
      32'h0,
      MSI_EN  ? {MSI_CTL_INIT, MSI_NEXT, CAPID_MSI}   : 32'h0,
      MSIX_EN ? {MSIX_CTL_INIT, 8'h00, CAPID_MSIX}   : 32'h0};

   // elaboration-time parameter checks
   if (IDX_W <= $clog2(NUM_REGS)) begin : g_bad_idxw
      $error("IDX_W must reach past NUM_REGS");
   end
   if (NUM_REGS <= CAP_HI_DW) begin : g_bad_depth
      $error("NUM_REGS too small for the capability region");
   end
   if (MSI_DW < CAP_LO_DW || MSI_DW > CAP_HI_DW ||
       MSIX_DW < CAP_LO_DW || MSIX_DW > CAP_HI_DW || MSI_DW == MSIX_DW) begin : g_bad_cap
      $error("capability dwords must be distinct and inside 0x40..0xBF");
   end
   if (BAR_SIZE_LOG2 < 4 || BAR_SIZE_LOG2 > 63) begin : g_bad_bar
      $error("BAR_SIZE_LOG2 out of range");
   end

   logic          acc_ok, acc_full;
   logic [DW-1:0] acc_lane, acc_data;
   logic          all_ones, rom_sizing;
   logic [DW-1:0] sl_q   [NSLOT];
   logic [DW-1:0] sl_nxt [NSLOT];
   logic [NSLOT-1:0] sl_hit;

   cfgsp_access_dec #(.DW(DW)) u_dec (
      .off(wr_off), .len(wr_len), .data(wr_data),
      .ok(acc_ok), .full(acc_full), .lane(acc_lane), .data_sh(acc_data)
   );

   assign all_ones   = acc_full && (wr_data == '1);
   assign rom_sizing = acc_full && (&wr_data[31:11]);

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      logic [DW-1:0] narrow;
      logic          we;
      assign sl_hit[s] = wr_en && acc_ok && (wr_idx == IDX_W'(SL_IDX[s]));
      if (s == SL_BLO) begin : g_nlo
         assign narrow = all_ones ? BAR_SZ_MASK[31:0] : '1;
         assign we     = sl_hit[s];
      end else if (s == SL_BHI) begin : g_nhi
         assign narrow = all_ones ? BAR_SZ_MASK[63:32] : '1;
         assign we     = sl_hit[s];
      end else if (s == SL_ROM) begin : g_nrom
         assign narrow = '1;
         assign we     = sl_hit[s] && !rom_sizing;
      end else begin : g_nplain
         assign narrow = '1;
         assign we     = sl_hit[s];
      end
      cfgsp_slot #(.DW(DW), .RST_VAL(SL_RST[s]), .WMASK(SL_WM[s])) u_slot (
         .clk(clk), .rst(rst), .we(we), .lane(acc_lane), .narrow(narrow),
         .data(acc_data), .q(sl_q[s]), .d_nxt(sl_nxt[s])
      );
   end

   always_comb begin
      rd_data = '0;
      if (rd_idx >= IDX_W'(NUM_REGS))                 rd_data = '1;
      else if (rd_idx == IDX_W'(IDX_ID))              rd_data = {DEVICE_ID, VENDOR_ID};
      else if (rd_idx == IDX_W'(IDX_CLASS))           rd_data = {CLASS_CODE, REVISION};
      else if (rd_idx == IDX_W'(IDX_SUBSYS))          rd_data = SUBSYS_ID;
      else if (rd_idx == IDX_W'(IDX_CAPPTR))          rd_data = {24'h0, FIRST_CAP};
      else begin
         for (int s = 0; s < NSLOT; s++) begin
            if (rd_idx == IDX_W'(SL_IDX[s])) rd_data = sl_q[s];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         msix_ctl_stb <= 1'b0;
         msix_ctl_val <= '0;
      end else begin
         msix_ctl_stb <= MSIX_EN && sl_hit[SL_MSIX] &&
                         (acc_full || (wr_len == 3'd2 && wr_off == 2'd2));
         if (sl_hit[SL_MSIX]) msix_ctl_val <= sl_nxt[SL_MSIX][31:16];
      end
   end
endmodule

// File: rtl/cfgsp_chk.sv
module cfgsp_chk
   import cfgsp_pkg::*;
#(
   parameter int NUM_REGS = 1024,
   parameter int IDX_W    = 12,
   parameter bit MSI_EN   = 1'b1,
   parameter bit MSIX_EN  = 1'b1,
   parameter int MSI_DW   = 16,
   parameter int MSIX_DW  = 20
) (
   input logic             clk,
   input logic             rst,
   input logic             wr_en,
   input logic [IDX_W-1:0] wr_idx,
   input logic [1:0]       wr_off,
   input logic [2:0]       wr_len,
   input logic [31:0]      wr_data,
   input logic [IDX_W-1:0] rd_idx,
   input logic [31:0]      rd_data,
   input logic             msix_ctl_stb
);
   AST_OOR_ALL_ONES: assert property (@(posedge clk) disable iff (rst)
      (rd_idx >= IDX_W'(NUM_REGS)) |-> (rd_data == 32'hFFFF_FFFF)); // R1

   AST_BAR_TYPE_FIXED: assert property (@(posedge clk) disable iff (rst)
      (rd_idx == IDX_W'(IDX_BAR_LO)) |-> (rd_data[3:0] == BAR_TYPE64)); // R6

   AST_ROM_SIZING_IGNORED: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_idx == IDX_W'(IDX_ROM) && wr_len == 3'd4 && wr_off == 2'd0 &&
       (&wr_data[31:11]) && rd_idx == IDX_W'(IDX_ROM))
      |=> (rd_idx != IDX_W'(IDX_ROM) || rd_data == $past(rd_data))); // R8

   AST_STATUS_CAP_BIT: assert property (@(posedge clk) disable iff (rst)
      (rd_idx == IDX_W'(IDX_CMD)) |-> (rd_data[STATUS_CAP_BIT] == (MSI_EN | MSIX_EN))); // R9

   AST_MSI_ID_FIXED: assert property (@(posedge clk) disable iff (rst)
      (MSI_EN && rd_idx == IDX_W'(MSI_DW)) |-> (rd_data[7:0] == CAPID_MSI)); // R10

   AST_MSIX_ID_FIXED: assert property (@(posedge clk) disable iff (rst)
      (MSIX_EN && rd_idx == IDX_W'(MSIX_DW)) |-> (rd_data[15:0] == {8'h00, CAPID_MSIX})); // R11

   AST_STB_CAUSE: assert property (@(posedge clk) disable iff (rst)
      $rose(msix_ctl_stb) |-> $past(wr_en && wr_idx == IDX_W'(MSIX_DW))); // R12

   AST_STB_PULSE: assert property (@(posedge clk) disable iff (rst)
      msix_ctl_stb |=> (!msix_ctl_stb || $past(wr_en && wr_idx == IDX_W'(MSIX_DW)))); // R12
endmodule

bind cfgsp_top cfgsp_chk #(
   .NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .MSI_EN(MSI_EN), .MSIX_EN(MSIX_EN),
   .MSI_DW(MSI_DW), .MSIX_DW(MSIX_DW)
) u_chk (
   .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_off(wr_off),
   .wr_len(wr_len), .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
   .msix_ctl_stb(msix_ctl_stb)
);

// File: tb/cfgsp_top_tb_top.sv
module cfgsp_top_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NREG  = 1024;
   localparam int IDXW  = 12;
   localparam int MSIDW = 16;
   localparam int MSXDW = 20;

   logic clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic            rst;
   logic            wr_en;
   logic [IDXW-1:0] wr_idx, rd_idx;
   logic [1:0]      wr_off;
   logic [2:0]      wr_len;
   logic [31:0]     wr_data, rd_data;
   logic            msix_ctl_stb;
   logic [15:0]     msix_ctl_val;

   cfgsp_top #(
      .NUM_REGS(NREG), .IDX_W(IDXW), .VENDOR_ID(16'hC0DE), .DEVICE_ID(16'h7A31),
      .REVISION(8'h02), .CLASS_CODE(24'h040100), .SUBSYS_ID(32'h2468_ABCD),
      .BAR_BASE(64'h0000_0013_1200_0000), .BAR_SIZE_LOG2(15),
      .ROM_WMASK(32'hFFFF_F801), .MSI_EN(1'b1), .MSIX_EN(1'b1),
      .MSI_DW(MSIDW), .MSIX_DW(MSXDW), .MSI_CTL_INIT(16'h0080), .MSIX_CTL_INIT(16'h03FF)
   ) dut_i (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_off(wr_off),
      .wr_len(wr_len), .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
      .msix_ctl_stb(msix_ctl_stb), .msix_ctl_val(msix_ctl_val)
   );

   bit [31:0] m_reg [NREG];
   bit [31:0] m_wm  [NREG];
   bit [31:0] m_sz  [6];
   bit        exp_stb;
   bit [15:0] exp_val;
   int n_vec = 0;
   int n_bad = 0;

   task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   function automatic void mdl_reset();
      for (int i = 0; i < NREG; i++) begin
         m_reg[i] = 0;
         m_wm[i]  = 0;
      end
      m_reg[0]  = 32'h7A31_C0DE;
      m_reg[1]  = 32'h0010_0000;  m_wm[1]  = 32'h0000_FFFF;
      m_reg[2]  = 32'h0401_0002;
      m_wm[3]   = 32'h0000_00FF;
      m_reg[4]  = 32'h1200_0004;  m_wm[4]  = 32'hFFFF_FFF0;
      m_reg[5]  = 32'h0000_0013;  m_wm[5]  = 32'hFFFF_FFFF;
      m_reg[11] = 32'h2468_ABCD;
      m_wm[12]  = 32'hFFFF_F801;
      m_reg[13] = 32'h0000_0040;
      m_wm[15]  = 32'h0000_00FF;
      m_reg[MSIDW] = 32'h0080_5005; m_wm[MSIDW] = 32'h0071_0000;
      m_reg[MSXDW] = 32'h03FF_0011; m_wm[MSXDW] = 32'hC000_0000;
      for (int b = 0; b < 6; b++) m_sz[b] = 0;
      m_sz[0] = 32'hFFFF_8000;
      m_sz[1] = 32'hFFFF_FFFF;
   endfunction

   function automatic bit [31:0] mdl_read(int idx);
      return (idx >= NREG) ? 32'hFFFF_FFFF : m_reg[idx];
   endfunction

   function automatic void mdl_write(int idx, int off, int len, bit [31:0] d);
      bit [31:0] w, msk, lanes, sd;
      exp_stb = 0;
      if (idx >= NREG) return;
      if (!(len == 1 || len == 2 || len == 4)) return;
      if (off + len > 4) return;
      if (len == 2 && off != 0 && off != 2) return;
      w = m_wm[idx];
      if (len == 4) begin
         msk = w;
         if (idx >= 4 && idx <= 9 && d == 32'hFFFF_FFFF) msk = msk & m_sz[idx-4];
         if (idx == 12 && d[31:11] == 21'h1F_FFFF) return;
         m_reg[idx] = (m_reg[idx] & ~w) | (d & msk);
      end else begin
         lanes = ((len == 1) ? 32'hFF : 32'hFFFF) << (off * 8);
         sd    = d << (off * 8);
         m_reg[idx] = (m_reg[idx] & ~(lanes & w)) | (sd & lanes & w);
      end
      if (idx == MSXDW && ((len == 2 && off == 2) || len == 4)) begin
         exp_stb = 1;
         exp_val = m_reg[idx][31:16];
      end
   endfunction

   task automatic rd_check(int idx, string rq);
      @(negedge clk);
      rd_idx = IDXW'(idx);
      #1;
      chk(rq, rd_data, mdl_read(idx));
      chk("R12 idle strobe", {31'b0, msix_ctl_stb}, 32'd0);
   endtask

   task automatic do_write(int idx, int off, int len, bit [31:0] d, string rq);
      @(negedge clk);
      wr_en = 1; wr_idx = IDXW'(idx); wr_off = 2'(off); wr_len = 3'(len); wr_data = d;
      rd_idx = IDXW'(idx);
      @(posedge clk);
      mdl_write(idx, off, len, d);
      @(negedge clk);
      wr_en = 0;
      #1;
      chk(rq, rd_data, mdl_read(idx));
      chk("R12 strobe", {31'b0, msix_ctl_stb}, {31'b0, exp_stb});
      if (exp_stb) chk("R12 value", {16'b0, msix_ctl_val}, {16'b0, exp_val});
   endtask

   task automatic apply_reset();
      @(negedge clk);
      rst = 1;
      repeat (3) @(posedge clk);
      mdl_reset();
      @(negedge clk);
      rst = 0;
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      rst = 1; wr_en = 0; wr_idx = 0; wr_off = 0; wr_len = 0; wr_data = 0; rd_idx = 0;
      apply_reset();
      // reset state
      rd_check(0, "R3 id");
      rd_check(2, "R3 class");
      rd_check(11, "R3 subsys");
      rd_check(1, "R9 status bit");
      rd_check(13, "R9 cap pointer");
      rd_check(MSIDW, "R10 msi header");
      rd_check(MSXDW, "R11 msix header");
      rd_check(4, "R6 bar low reset");
      rd_check(5, "R6 bar high reset");
      rd_check(12, "R8 rom reset");
      rd_check(1024, "R1 out of range");
      rd_check(4095, "R1 top index");
      // masked merge
      do_write(1, 0, 4, 32'hFFFF_FFFF, "R2 command dword");
      do_write(1, 0, 4, 32'h0000_1234, "R2 command pattern");
      do_write(0, 0, 4, 32'h1111_2222, "R3 id read only");
      do_write(2, 2, 2, 32'h0000_FFFF, "R3 class read only");
      do_write(3, 1, 1, 32'h0000_00AB, "R2 cacheline ro lane");
      do_write(3, 0, 1, 32'h0000_00AB, "R2 cacheline byte");
      do_write(15, 0, 1, 32'h0000_005A, "R2 interrupt line");
      do_write(1, 1, 1, 32'h0000_00C3, "R4 byte lane 1");
      do_write(1, 2, 2, 32'h0000_FFFF, "R4 word at 2 ro half");
      // dropped accesses
      do_write(1, 1, 2, 32'h0000_0000, "R4 word at 1 dropped");
      do_write(1, 3, 2, 32'h0000_0000, "R5 word at 3 dropped");
      do_write(1, 1, 4, 32'h0000_0000, "R5 dword at 1 dropped");
      do_write(1, 0, 3, 32'h0000_0000, "R5 len 3 dropped");
      do_write(3, 0, 0, 32'h0000_0000, "R5 len 0 dropped");
      // BAR
      do_write(4, 0, 4, 32'hFFFF_FFFF, "R7 bar low sizing");
      do_write(5, 0, 4, 32'hFFFF_FFFF, "R7 bar high sizing");
      do_write(4, 0, 4, 32'h4200_000F, "R6 bar low address");
      do_write(5, 0, 4, 32'h0000_0084, "R6 bar high address");
      do_write(4, 2, 2, 32'h0000_FFFF, "R6 bar low word");
      do_write(6, 0, 4, 32'hFFFF_FFFF, "R7 unused bar");
      // ROM
      do_write(12, 0, 4, 32'h0000_0042, "R8 rom low bits");
      do_write(12, 0, 4, 32'hFFFF_FFFF, "R8 rom sizing");
      do_write(12, 0, 4, 32'h0001_0001, "R8 rom address");
      do_write(12, 0, 4, 32'hFFFF_F800, "R8 rom sizing kept");
      do_write(12, 3, 1, 32'h0000_00FF, "R8 rom byte");
      // MSI / MSI-X
      do_write(MSIDW, 0, 4, 32'hFFFF_FFFF, "R10 msi set");
      do_write(MSIDW, 2, 2, 32'h0000_0000, "R10 msi clear");
      do_write(MSXDW, 2, 2, 32'h0000_FFFF, "R11 msix word");
      do_write(MSXDW, 0, 4, 32'h4000_0000, "R11 msix dword");
      do_write(MSXDW, 3, 1, 32'h0000_00FF, "R12 byte no strobe");
      do_write(MSXDW, 0, 2, 32'h0000_FFFF, "R12 low word no strobe");
      do_write(MSXDW, 2, 2, 32'h0000_0000, "R12 strobe clear");
      // out of range
      do_write(1024, 0, 4, 32'h0000_0000, "R1 write oor");
      do_write(2000, 2, 2, 32'h0000_1234, "R1 write oor word");
      for (int i = 0; i < NREG + 4; i++) rd_check(i, "R1 R13 sweep");
      // second reset
      apply_reset();
      for (int i = 0; i < 24; i++) rd_check(i, "R13 reset restore");
      summary();
      $finish;
   end
endmodule